// File: doc/BRIEF.md
# Tag Phase Error Calculator

This block sits beside the tag capture logic of a digital PLL. It keeps the most recent reference-clock tag and main-clock tag, each with its own ready flag. From the two tags it produces two signed errors, each reduced modulo a beating period of 2^PERIOD_LOG2 counts. The period error is the wrapping negation of the reference tag. The phase error is the main tag minus the reference tag minus a programmable skew offset, all computed with wrapping 32-bit arithmetic. The loop filter consumes a result by pulsing a take strobe, and the take strobe clears both ready flags.

The skew offset is held in a register that can be written and read back at any time. This lets a calibration routine sweep the offset while it watches a timing checker elsewhere. Its reset value depends on where the reference clock comes from. When the reference is recovered from the serial link (`REF_FROM_PIN = 0`), it resets to 19050 counts. When the reference comes from an external clock input (`REF_FROM_PIN = 1`), it resets to 0.

Top module: `tag_phase_calc`

## Requirements
- R1: After reset both ready flags are clear, so `err_valid` is 0. `ofs_rdata` reads 19050 when `REF_FROM_PIN = 0` and reads 0 when `REF_FROM_PIN = 1`.
- R2: A cycle with `ref_stb` high stores `ref_tag` and sets the reference flag. A cycle with `main_stb` high stores `main_tag` and sets the main flag. `err_valid` is 1 only while both flags are set.
- R3: `period_err` is (0 − reference tag) mod 2^32, then reduced modulo P = 2^PERIOD_LOG2 and mapped as in R5.
- R4: `phase_err` is (main tag − reference tag − offset) mod 2^32, then reduced modulo P and mapped as in R5.
- R5: A residue r in [0, P) is reported as r when r < P/2 and as r − P otherwise. Both errors therefore lie in [−P/2, P/2), sign-extended to 32 bits.
- R6: A cycle with `err_take` high clears both ready flags. `err_valid` is 0 from the next cycle on.
- R7: A tag strobe in the same cycle as `err_take` wins for its own slot. That flag ends up set and the new tag is stored.
- R8: A cycle with `ofs_we` high loads `ofs_wdata` into the offset register. From the next cycle the new value appears on `ofs_rdata` and is used by `phase_err`. Without a write, the offset holds its value.
- R9: With no strobe, a stored tag holds its value. A later strobe replaces it, so the latest tag is always the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | Reference tag capture strobe |
| ref_tag | input | 32 | Reference-clock tag value |
| main_stb | input | 1 | Main tag capture strobe |
| main_tag | input | 32 | Main-clock tag value |
| err_take | input | 1 | Result consumed; clears both ready flags |
| ofs_we | input | 1 | Skew offset write enable |
| ofs_wdata | input | 32 | Skew offset write value |
| ofs_rdata | output | 32 | Current skew offset |
| err_valid | output | 1 | Both tags captured since the last take |
| period_err | output | 32 | Signed period error |
| phase_err | output | 32 | Signed phase error |

## Verification
The bench targets residues that land exactly on P/2 and at P/2 − 1. A design with an off-by-one in the fold would report +P/2 instead of −P/2, or would flip the sign of the largest positive error. It also feeds tags near 2^32 and a main tag numerically below the reference plus offset. A design that reduced before wrapping, or that used a signed remainder, would give errors that are off by a multiple of P. Finally, it fires a tag strobe in the same cycle as a take, and checks both reset values of the offset. A design that let the clear win would stall `err_valid`, and one with a single reset default would fail one of the two instances.

// File: rtl/tag_phase_pkg.sv
package tag_phase_pkg;
    localparam int TAG_W = 32;
    localparam int SKEW_DEFAULT_LINK = 19050;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        tag_t tag;
        logic rdy;
    } slot_t;
endpackage

// File: rtl/tpc_tag_slot.sv
module tpc_tag_slot
    import tag_phase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  tag_t tag_in,
    input  logic clr,
    output tag_t tag_q,
    output logic rdy_q
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.rdy = 1'b0;
        end
        if (stb) begin
            s_d.tag = tag_in;
            s_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tag_q = s_q.tag;
    assign rdy_q = s_q.rdy;

    // R2 / R7: a strobe always stores its tag and sets the flag
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (rdy_q && tag_q == $past(tag_in)));

    // R6: a take without a strobe clears the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !stb) |=> !rdy_q);

    // R9: no strobe and no take leaves the slot untouched
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> ($stable(tag_q) && $stable(rdy_q)));
endmodule

// File: rtl/tpc_skew_reg.sv
module tpc_skew_reg
    import tag_phase_pkg::*;
#(
    parameter tag_t RESET_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  tag_t wdata,
    output tag_t ofs_q
);
    tag_t ofs_d, ofs_r;

    always_comb begin
        ofs_d = ofs_r;
        if (we) begin
            ofs_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_r <= RESET_VAL;
        end else begin
            ofs_r <= ofs_d;
        end
    end

    assign ofs_q = ofs_r;

    // R8: a write lands on the read port one cycle later
    a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ofs_q == $past(wdata)));

    // R8: without a write the offset holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ofs_q));
endmodule

// File: rtl/tpc_fold.sv
module tpc_fold
    import tag_phase_pkg::*;
#(
    parameter int PERIOD_LOG2 = 15
) (
    input  tag_t                    diff,
    output logic signed [TAG_W-1:0] err
);
    localparam tag_t PERIOD = tag_t'(1) << PERIOD_LOG2;
    localparam tag_t HALF   = PERIOD >> 1;
    localparam tag_t MASK   = PERIOD - tag_t'(1);

    tag_t residue;

    always_comb begin
        residue = diff & MASK;
        if (residue >= HALF) begin
            err = $signed(residue - PERIOD);
        end else begin
            err = $signed(residue);
        end
    end
endmodule

// File: rtl/tag_phase_calc.sv
module tag_phase_calc
    import tag_phase_pkg::*;
#(
    parameter int PERIOD_LOG2  = 15,
    parameter bit REF_FROM_PIN = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_stb,
    input  logic [31:0] ref_tag,
    input  logic        main_stb,
    input  logic [31:0] main_tag,
    input  logic        err_take,
    input  logic        ofs_we,
    input  logic [31:0] ofs_wdata,
    output logic [31:0] ofs_rdata,
    output logic        err_valid,
    output logic [31:0] period_err,
    output logic [31:0] phase_err
);
    localparam int   NSLOT     = 2;
    localparam tag_t SKEW_INIT = REF_FROM_PIN ? tag_t'(0) : tag_t'(SKEW_DEFAULT_LINK);

    logic [NSLOT-1:0] stb_v;
    tag_t             tin_v [NSLOT];
    tag_t             tq_v  [NSLOT];
    logic [NSLOT-1:0] rdy_v;

    assign stb_v    = {main_stb, ref_stb};
    assign tin_v[0] = ref_tag;
    assign tin_v[1] = main_tag;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        tpc_tag_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (stb_v[i]),
            .tag_in (tin_v[i]),
            .clr    (err_take),
            .tag_q  (tq_v[i]),
            .rdy_q  (rdy_v[i])
        );
    end

    tag_t ofs_q;

    tpc_skew_reg #(.RESET_VAL(SKEW_INIT)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ofs_we),
        .wdata (ofs_wdata),
        .ofs_q (ofs_q)
    );

    tag_t period_raw, phase_raw;
    logic signed [TAG_W-1:0] period_s, phase_s;

    assign period_raw = tag_t'(0) - tq_v[0];
    assign phase_raw  = tq_v[1] - tq_v[0] - ofs_q;

    tpc_fold #(.PERIOD_LOG2(PERIOD_LOG2)) u_fold_period (
        .diff (period_raw),
        .err  (period_s)
    );

    tpc_fold #(.PERIOD_LOG2(PERIOD_LOG2)) u_fold_phase (
        .diff (phase_raw),
        .err  (phase_s)
    );

    assign ofs_rdata  = ofs_q;
    assign err_valid  = &rdy_v;
    assign period_err = period_s;
    assign phase_err  = phase_s;

    // R7: a take in the same cycle as both strobes leaves a valid result
    a_r7_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (err_take && ref_stb && main_stb) |=> err_valid);
endmodule

// File: tb/tag_phase_calc_bench.sv
`timescale 1ns/1ps
module tag_phase_calc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_stb = 1'b0, main_stb = 1'b0, err_take = 1'b0, ofs_we = 1'b0;
    logic [31:0] ref_tag = '0, main_tag = '0, ofs_wdata = '0;
    logic [31:0] ofs_rdata, period_err, phase_err, ofs_rdata_ext, pe_x, ph_x;
    logic        err_valid, valid_x;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tag_phase_calc u_tag_phase_calc (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .ref_tag(ref_tag),
        .main_stb(main_stb), .main_tag(main_tag), .err_take(err_take),
        .ofs_we(ofs_we), .ofs_wdata(ofs_wdata), .ofs_rdata(ofs_rdata),
        .err_valid(err_valid), .period_err(period_err), .phase_err(phase_err)
    );

    tag_phase_calc #(.REF_FROM_PIN(1'b1)) u_tag_phase_calc_ext (
        .clk(clk), .rst_n(rst_n), .ref_stb(1'b0), .ref_tag(32'd0),
        .main_stb(1'b0), .main_tag(32'd0), .err_take(1'b0),
        .ofs_we(1'b0), .ofs_wdata(32'd0), .ofs_rdata(ofs_rdata_ext),
        .err_valid(valid_x), .period_err(pe_x), .phase_err(ph_x)
    );

    // columns: ref tag, main tag, offset, expected period error, expected phase error (P = 32768)
    localparam int NVEC = 7;
    localparam int VEC [NVEC][5] = '{
        '{0,     0,     0,     0,      0},
        '{100,   300,   0,     -100,   200},
        '{16384, 0,     0,     -16384, -16384},
        '{16383, 32766, 0,     -16383, 16383},
        '{5,     3,     19050, -5,     13716},
        '{32775, -16,   1,     -7,     -24},
        '{-1,    0,     0,     1,      1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state, both reference modes
        chk("R1 valid after reset", {31'd0, err_valid}, 32'd0);
        chk("R1 offset default link mode", ofs_rdata, 32'd19050);
        chk("R1 offset default pin mode", ofs_rdata_ext, 32'd0);

        // table walk: R3, R4, R5, R6, R8
        for (int v = 0; v < NVEC; v++) begin
            ofs_we = 1'b1; ofs_wdata = VEC[v][2];
            tick();
            ofs_we = 1'b0;
            chk("R8 offset readback", ofs_rdata, VEC[v][2]);
            ref_stb = 1'b1; main_stb = 1'b1;
            ref_tag = VEC[v][0]; main_tag = VEC[v][1];
            tick();
            ref_stb = 1'b0; main_stb = 1'b0;
            chk("R2 valid after both tags", {31'd0, err_valid}, 32'd1);
            chk("R3 R5 period error", period_err, VEC[v][3]);
            chk("R4 R5 phase error", phase_err, VEC[v][4]);
            err_take = 1'b1;
            tick();
            err_take = 1'b0;
            chk("R6 take clears valid", {31'd0, err_valid}, 32'd0);
        end

        // R2: only one tag does not make a result valid
        ofs_we = 1'b1; ofs_wdata = 32'd0;
        tick();
        ofs_we = 1'b0;
        ref_stb = 1'b1; ref_tag = 32'd10;
        tick();
        ref_stb = 1'b0;
        chk("R2 ref only not valid", {31'd0, err_valid}, 32'd0);
        main_stb = 1'b1; main_tag = 32'd50;
        tick();
        main_stb = 1'b0;
        chk("R2 main completes pair", {31'd0, err_valid}, 32'd1);

        // R9: tags hold without strobes, then latest tag replaces
        repeat (4) tick();
        chk("R9 phase held", phase_err, 32'd40);
        chk("R9 period held", period_err, -32'sd10);
        ref_stb = 1'b1; ref_tag = 32'd20;
        tick();
        ref_stb = 1'b0;
        chk("R9 newest ref used", phase_err, 32'd30);

        // R7: strobe in the take cycle wins for its slot
        err_take = 1'b1; ref_stb = 1'b1; ref_tag = 32'd7;
        tick();
        err_take = 1'b0; ref_stb = 1'b0;
        chk("R7 main flag cleared", {31'd0, err_valid}, 32'd0);
        main_stb = 1'b1; main_tag = 32'd9;
        tick();
        main_stb = 1'b0;
        chk("R7 ref flag kept", {31'd0, err_valid}, 32'd1);
        chk("R7 ref tag stored", phase_err, 32'd2);

        // R8: offset change feeds phase error, holds without write
        ofs_we = 1'b1; ofs_wdata = 32'd5;
        tick();
        ofs_we = 1'b0;
        chk("R8 offset in phase error", phase_err, -32'sd3);
        repeat (2) tick();
        chk("R8 offset holds", ofs_rdata, 32'd5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule